// File: doc/BRIEF.md
# Video Line-Slice Interrupt Unit

This unit follows the timing of an incoming video stream and reports when each part of a frame has arrived. A frame starts on the rising edge of `vsync`. A line has been captured when `line_valid` falls. The unit counts the captured lines of the current frame. A set of line comparators, one per slice, raises an event when the count reaches the line programmed for it. A further event marks the end of the frame, which is the line that brings the count up to the frame height. Software can then process a frame in slices while the rest of the frame is still arriving. For example, a 720-line frame with comparators at 180, 360 and 540 gives four slices of 180 lines each. All events follow only the input timing.

The unit also holds the frame base address in two stages. Software may write the pending address at any moment. The address presented to the capture path changes only at the next frame start. A comparator programmed to line 0 therefore fires at the moment the address changes, so software can retire the previous buffer at that point.

Each event sets a sticky status bit. Two separate select masks decide where the event goes. One mask drives the level interrupt `irq`. The other mask drives one-cycle DMA trigger pulses. Registers are accessed through a simple single-cycle port. Reads are combinational. Register map: 0x0 frame height, 0x1 interrupt select, 0x2 DMA select, 0x3 status (write 1 to clear), 0x4 pending base, 0x5 active base (read-only), 0x8+k comparator k. In every mask and in the status register, bit k (k below N_SLICE) belongs to comparator k, and bit N_SLICE (bit 3 by default) belongs to end of frame.

Top module: `vcap_slice_irq`

## Requirements
- R1: The line count is cleared on a `vsync` rising edge. It then goes up by one at each falling edge of `line_valid` and stops at the frame height in force for that frame. A `line_valid` fall in the same cycle as a `vsync` rise is not counted.
- R2: Comparator k sets status bit k once per frame, in the cycle of the `line_valid` fall that brings the count to its programmed value N (1 ≤ N < height).
- R3: A comparator programmed to 0 sets its status bit at the `vsync` rising edge, provided the frame height is not 0.
- R4: A comparator value greater than or equal to the frame height never sets its status bit.
- R5: The end-of-frame bit (bit N_SLICE) is set once, on the line that brings the count to the height. Lines that arrive after that raise no event.
- R6: Writes to the comparators or to the height during a frame take effect only from the next `vsync` rising edge.
- R7: `frame_base` changes only on a `vsync` rising edge. It then takes the pending address that was held before that edge.
- R8: Writing 1 to a bit of the status register (0x3) clears that bit. If an event sets the same bit in the same cycle, the bit stays set.
- R9: `irq` is high exactly while some status bit and the matching bit of the interrupt select mask (0x1) are both 1.
- R10: `dma_evt[k]` pulses high for one cycle, in the cycle after event k, when bit k of the DMA select mask (0x2) is 1. This does not depend on the interrupt select mask or on the status register.
- R11: After reset, all of the following hold:
  - status, both masks, the height, the pending base and `frame_base` are 0;
  - comparators read all ones;
  - `irq` and `dma_evt` are low;
  - no event occurs before the first `vsync` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Frame sync; a rising edge starts a frame |
| line_valid | input | 1 | High during active line data; a falling edge ends a line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt to the CPU |
| dma_evt | output | N_SLICE+1 | One-cycle DMA trigger pulses, one per event source |
| frame_base | output | DATA_W | Active frame base address |

## Verification
The embedded assertions check these properties on every cycle:
- the line count never goes above the shadowed height;
- shadowed comparators and the active base address change only at frame start;
- the active base takes the pending value when it changes;
- a status bit falls only after a clear write;
- DMA pulses follow an event and never last two cycles.

Some behaviours can only be shown by the bench's frame scenarios:
- the exact line at which each slice fires;
- the four equal slices of a 720-line frame;
- the line-0 event;
- comparators at or above the height staying silent;
- set winning over clear;
- the separation between interrupt and DMA routing.

// File: rtl/vcap_slice_pkg.sv
package vcap_slice_pkg;

    localparam int unsigned REG_AW = 4;

    localparam logic [REG_AW-1:0] RA_HEIGHT = 4'h0;
    localparam logic [REG_AW-1:0] RA_IRQSEL = 4'h1;
    localparam logic [REG_AW-1:0] RA_EVTSEL = 4'h2;
    localparam logic [REG_AW-1:0] RA_STATUS = 4'h3;
    localparam logic [REG_AW-1:0] RA_PEND   = 4'h4;
    localparam logic [REG_AW-1:0] RA_ACTIVE = 4'h5;
    localparam logic [REG_AW-1:0] RA_CMP0   = 4'h8;

endpackage

// File: rtl/vcap_line_track.sv
module vcap_line_track #(
    parameter int unsigned LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync,
    input  logic              line_valid,
    input  logic [LINE_W-1:0] height_cfg,
    output logic              frame_start,
    output logic              line_done,
    output logic [LINE_W-1:0] line_next,
    output logic [LINE_W-1:0] height_act
);

    typedef struct packed {
        logic              vs;
        logic              lv;
        logic              live;
        logic [LINE_W-1:0] cnt;
        logic [LINE_W-1:0] height;
    } trk_t;

    trk_t trk_d, trk_q;
    logic lv_fall;

    always_comb begin
        trk_d       = trk_q;
        trk_d.vs    = vsync;
        trk_d.lv    = line_valid;
        frame_start = vsync && !trk_q.vs;
        lv_fall     = trk_q.lv && !line_valid;
        line_next   = trk_q.cnt + 1'b1;
        line_done   = !frame_start && lv_fall && trk_q.live && (trk_q.cnt < trk_q.height);
        if (frame_start) begin
            trk_d.live   = 1'b1;
            trk_d.cnt    = '0;
            trk_d.height = height_cfg;
        end else if (line_done) begin
            trk_d.cnt = line_next;
        end
        height_act = trk_q.height;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    AST_CNT_WITHIN_HEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.cnt <= trk_q.height); // R1

    AST_CNT_CLEARED_AT_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && !trk_q.vs) |=> (trk_q.cnt == '0)); // R1

endmodule

// File: rtl/vcap_slice_cmp.sv
module vcap_slice_cmp #(
    parameter int unsigned LINE_W  = 12,
    parameter int unsigned N_SLICE = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            frame_start,
    input  logic                            line_done,
    input  logic [LINE_W-1:0]               line_next,
    input  logic [LINE_W-1:0]               height_cfg,
    input  logic [LINE_W-1:0]               height_act,
    input  logic [N_SLICE-1:0][LINE_W-1:0]  cmp_cfg,
    output logic [N_SLICE:0]                src_evt
);

    typedef struct packed {
        logic [N_SLICE-1:0][LINE_W-1:0] cmp;
    } shd_t;

    shd_t shd_d, shd_q;

    always_comb begin
        shd_d = shd_q;
        if (frame_start) begin
            shd_d.cmp = cmp_cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_q <= '1;
        end else begin
            shd_q <= shd_d;
        end
    end

    for (genvar k = 0; k < N_SLICE; k++) begin : g_cmp
        logic at_start;
        logic at_line;
        assign at_start   = frame_start && (cmp_cfg[k] == '0) && (cmp_cfg[k] < height_cfg);
        assign at_line    = line_done && (shd_q.cmp[k] == line_next) && (shd_q.cmp[k] < height_act);
        assign src_evt[k] = at_start || at_line;
    end

    assign src_evt[N_SLICE] = line_done && (line_next == height_act);

    AST_SHADOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(shd_q)); // R6

endmodule

// File: rtl/vcap_irq_route.sv
module vcap_irq_route #(
    parameter int unsigned N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_evt,
    input  logic [N_SRC-1:0] irq_sel,
    input  logic [N_SRC-1:0] evt_sel,
    input  logic             clr_en,
    input  logic [N_SRC-1:0] clr_mask,
    output logic [N_SRC-1:0] status,
    output logic             irq,
    output logic [N_SRC-1:0] dma_evt
);

    typedef struct packed {
        logic [N_SRC-1:0] status;
        logic [N_SRC-1:0] dma;
    } rt_t;

    rt_t rt_d, rt_q;

    always_comb begin
        rt_d = rt_q;
        if (clr_en) begin
            rt_d.status = rt_q.status & ~clr_mask;
        end
        rt_d.status = rt_d.status | src_evt;
        rt_d.dma    = src_evt & evt_sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_q <= '0;
        end else begin
            rt_q <= rt_d;
        end
    end

    assign status  = rt_q.status;
    assign irq     = |(rt_q.status & irq_sel);
    assign dma_evt = rt_q.dma;

    AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(rt_q.status) & ~rt_q.status)) |-> $past(clr_en)); // R8

    AST_DMA_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_q.dma & $past(rt_q.dma)) == '0); // R10

    AST_DMA_FOLLOWS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (|rt_q.dma) |-> $past(|src_evt)); // R10

endmodule

// File: rtl/vcap_slice_irq.sv
module vcap_slice_irq
    import vcap_slice_pkg::*;
#(
    parameter int unsigned LINE_W  = 12,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned N_SLICE = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vsync,
    input  logic                 line_valid,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq,
    output logic [N_SLICE:0]     dma_evt,
    output logic [DATA_W-1:0]    frame_base
);

    localparam int unsigned N_SRC = N_SLICE + 1;

    typedef struct packed {
        logic [LINE_W-1:0]              height;
        logic [N_SLICE-1:0][LINE_W-1:0] cmp;
        logic [N_SRC-1:0]               irq_sel;
        logic [N_SRC-1:0]               evt_sel;
        logic [DATA_W-1:0]              pend;
        logic [DATA_W-1:0]              active;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              frame_start;
    logic              line_done;
    logic [LINE_W-1:0] line_next;
    logic [LINE_W-1:0] height_act;
    logic [N_SRC-1:0]  src_evt;
    logic [N_SRC-1:0]  status;
    logic              clr_en;

    assign clr_en = reg_we && (reg_addr == RA_STATUS);

    always_comb begin
        regs_d = regs_q;
        if (reg_we) begin
            case (reg_addr)
                RA_HEIGHT: regs_d.height  = reg_wdata[LINE_W-1:0];
                RA_IRQSEL: regs_d.irq_sel = reg_wdata[N_SRC-1:0];
                RA_EVTSEL: regs_d.evt_sel = reg_wdata[N_SRC-1:0];
                RA_PEND:   regs_d.pend    = reg_wdata;
                default:   ;
            endcase
            for (int k = 0; k < N_SLICE; k++) begin
                if (reg_addr == RA_CMP0 + REG_AW'(k)) begin
                    regs_d.cmp[k] = reg_wdata[LINE_W-1:0];
                end
            end
        end
        if (frame_start) begin
            regs_d.active = regs_q.pend;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q        <= '0;
            regs_q.cmp    <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_HEIGHT: reg_rdata[LINE_W-1:0] = regs_q.height;
            RA_IRQSEL: reg_rdata[N_SRC-1:0]  = regs_q.irq_sel;
            RA_EVTSEL: reg_rdata[N_SRC-1:0]  = regs_q.evt_sel;
            RA_STATUS: reg_rdata[N_SRC-1:0]  = status;
            RA_PEND:   reg_rdata             = regs_q.pend;
            RA_ACTIVE: reg_rdata             = regs_q.active;
            default:   ;
        endcase
        for (int k = 0; k < N_SLICE; k++) begin
            if (reg_addr == RA_CMP0 + REG_AW'(k)) begin
                reg_rdata[LINE_W-1:0] = regs_q.cmp[k];
            end
        end
    end

    assign frame_base = regs_q.active;

    vcap_line_track #(
        .LINE_W (LINE_W)
    ) i_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .vsync       (vsync),
        .line_valid  (line_valid),
        .height_cfg  (regs_q.height),
        .frame_start (frame_start),
        .line_done   (line_done),
        .line_next   (line_next),
        .height_act  (height_act)
    );

    vcap_slice_cmp #(
        .LINE_W  (LINE_W),
        .N_SLICE (N_SLICE)
    ) i_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_done   (line_done),
        .line_next   (line_next),
        .height_cfg  (regs_q.height),
        .height_act  (height_act),
        .cmp_cfg     (regs_q.cmp),
        .src_evt     (src_evt)
    );

    vcap_irq_route #(
        .N_SRC (N_SRC)
    ) i_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_evt  (src_evt),
        .irq_sel  (regs_q.irq_sel),
        .evt_sel  (regs_q.evt_sel),
        .clr_en   (clr_en),
        .clr_mask (reg_wdata[N_SRC-1:0]),
        .status   (status),
        .irq      (irq),
        .dma_evt  (dma_evt)
    );

    AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(regs_q.active)); // R7

    AST_BASE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (regs_q.active == $past(regs_q.pend))); // R7

endmodule

// File: tb/test_vcap_slice_irq.sv
module test_vcap_slice_irq;
    import vcap_slice_pkg::*;

    localparam int NS   = 3;
    localparam int NSRC = NS + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            vsync = 1'b0;
    logic            line_valid = 1'b0;
    logic            reg_we = 1'b0;
    logic [3:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            irq;
    logic [NSRC-1:0] dma_evt;
    logic [31:0]     frame_base;

    vcap_slice_irq i_vcap_slice_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .vsync      (vsync),
        .line_valid (line_valid),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq),
        .dma_evt    (dma_evt),
        .frame_base (frame_base)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int n_pulse = 0;
    bit done = 0;

    // bench-side model of the programmed state
    int              cfg_h = 0;
    int              cur_h = 0;
    int              cfg_cmp [NS];
    int              cur_cmp [NS];
    int              cnt = 0;
    bit              live = 0;
    logic [NSRC-1:0] m_irqsel = '0;
    logic [NSRC-1:0] m_evtsel = '0;
    logic [NSRC-1:0] m_status = '0;
    logic [31:0]     m_pend = '0;
    logic [31:0]     m_active = '0;
    logic [NSRC-1:0] exp_q [$];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic post(input logic [NSRC-1:0] ev);
        m_status = m_status | ev;
        if ((ev & m_evtsel) != '0) exp_q.push_back(ev & m_evtsel);
    endtask

    task automatic model_write(input logic [3:0] a, input logic [31:0] d);
        case (a)
            RA_HEIGHT: cfg_h = int'(d[11:0]);
            RA_IRQSEL: m_irqsel = d[NSRC-1:0];
            RA_EVTSEL: m_evtsel = d[NSRC-1:0];
            RA_STATUS: m_status = m_status & ~d[NSRC-1:0];
            RA_PEND:   m_pend = d;
            default: begin
                for (int k = 0; k < NS; k++)
                    if (a == RA_CMP0 + 4'(k)) cfg_cmp[k] = int'(d[11:0]);
            end
        endcase
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        model_write(a, d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic vs_pulse();
        logic [NSRC-1:0] ev;
        @(negedge clk);
        vsync = 1'b1;
        cur_h = cfg_h;
        for (int k = 0; k < NS; k++) cur_cmp[k] = cfg_cmp[k];
        cnt = 0; live = 1; m_active = m_pend;
        ev = '0;
        for (int k = 0; k < NS; k++) if (cur_cmp[k] == 0 && cur_h > 0) ev[k] = 1'b1;
        post(ev);
        @(negedge clk);
        vsync = 1'b0;
        @(negedge clk);
    endtask

    task automatic one_line(input int w, input logic [NSRC-1:0] clr);
        logic [NSRC-1:0] ev;
        @(negedge clk);
        line_valid = 1'b1;
        repeat (w - 1) @(negedge clk);
        @(negedge clk);
        line_valid = 1'b0;
        if (clr != '0) begin
            reg_we = 1'b1; reg_addr = RA_STATUS; reg_wdata = 32'(clr);
            m_status = m_status & ~clr;
        end
        ev = '0;
        if (live && cnt < cur_h) begin
            cnt++;
            for (int k = 0; k < NS; k++) if (cur_cmp[k] == cnt && cur_cmp[k] < cur_h) ev[k] = 1'b1;
            if (cnt == cur_h) ev[NS] = 1'b1;
        end
        post(ev);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic lines_irq(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            one_line(2, '0);
            check(req, irq, |(m_status & m_irqsel));
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // scoreboard monitor
    initial begin
        logic [NSRC-1:0] e;
        forever begin
            @(posedge clk);
            #5;
            if (rst_n && dma_evt !== '0) begin
                n_pulse++;
                if (exp_q.size() == 0) begin
                    check("R10 unexpected dma pulse", 64'(dma_evt), 64'(0));
                end else begin
                    e = exp_q.pop_front();
                    check("R2/R5/R10 dma event order", 64'(dma_evt), 64'(e));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int p0;
        for (int k = 0; k < NS; k++) begin cfg_cmp[k] = 4095; cur_cmp[k] = 4095; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        check("R11 irq after reset", irq, 0);
        check("R11 dma_evt after reset", dma_evt, 0);
        check("R11 frame_base after reset", frame_base, 0);
        rd_check("R11 status after reset", RA_STATUS, 0);
        rd_check("R11 height after reset", RA_HEIGHT, 0);
        rd_check("R11 comparator after reset", RA_CMP0, 32'hFFF);

        // R11: no events before the first vsync
        wr(RA_HEIGHT, 4);
        wr(RA_CMP0, 1);
        wr(RA_IRQSEL, 32'hF);
        wr(RA_EVTSEL, 32'hF);
        lines_irq(5, "R11 no irq before vsync");
        rd_check("R11 status before vsync", RA_STATUS, 0);

        // R2/R5: 720-line frame split into four slices
        wr(RA_IRQSEL, 0);
        wr(RA_HEIGHT, 720);
        wr(RA_CMP0, 180);
        wr(RA_CMP0 + 4'd1, 360);
        wr(RA_CMP0 + 4'd2, 540);
        p0 = n_pulse;
        vs_pulse();
        for (int i = 1; i <= 720; i++) begin
            one_line(2, '0);
            if (i % 180 == 179 || i % 180 == 0)
                rd_check("R2 status at slice boundary", RA_STATUS, 32'(m_status));
        end
        repeat (3) @(negedge clk);
        check("R2 four slices per 720-line frame", n_pulse - p0, 4);
        check("R5 end-of-frame status", m_status[NS], 1);

        // R8: write-one-to-clear
        wr(RA_STATUS, 32'hF);
        rd_check("R8 status cleared", RA_STATUS, 0);

        // R3/R6/R7: small frame, line-0 comparator, mid-frame writes
        wr(RA_HEIGHT, 16);
        wr(RA_CMP0, 0);
        wr(RA_CMP0 + 4'd1, 8);
        wr(RA_CMP0 + 4'd2, 12);
        wr(RA_PEND, 32'h8000_1000);
        vs_pulse();
        rd_check("R3 line-0 comparator at frame start", RA_STATUS, 32'h1);
        check("R7 base switched at vsync", frame_base, 32'h8000_1000);
        lines_irq(2, "R9 irq level");
        wr(RA_CMP0 + 4'd2, 5);
        wr(RA_PEND, 32'h8000_2000);
        check("R7 base held mid-frame", frame_base, 32'h8000_1000);
        lines_irq(3, "R6 old comparator in force");
        rd_check("R6 no fire at new value mid-frame", RA_STATUS, 32'(m_status));
        check("R6 bit2 still clear at line 5", m_status[2], 0);
        lines_irq(14, "R1 saturating count");
        rd_check("R5 status after extra lines", RA_STATUS, 32'(m_status));
        check("R1/R5 end-of-frame seen once", m_status, 4'hF);
        check("R7 base held to frame end", frame_base, 32'h8000_1000);

        // R4/R7/R9/R8: comparator at height, irq routing, set beats clear
        wr(RA_STATUS, 32'hF);
        wr(RA_CMP0 + 4'd1, 16);
        wr(RA_CMP0, 3);
        wr(RA_IRQSEL, 32'h4);
        vs_pulse();
        check("R7 new base after vsync", frame_base, 32'h8000_2000);
        check("R9 irq low at frame start", irq, 0);
        lines_irq(4, "R9 irq before slice");
        one_line(2, 4'h4);
        rd_check("R8 set wins over clear", RA_STATUS, 32'(m_status));
        check("R8 bit2 held", m_status[2], 1);
        check("R9 irq after slice", irq, 1);
        lines_irq(11, "R9 irq through frame");
        rd_check("R4 comparator at height silent", RA_STATUS, 32'(m_status));
        check("R4 bit1 never set", m_status[1], 0);
        wr(RA_STATUS, 32'h4);
        check("R9 irq drops after clear", irq, |(m_status & m_irqsel));

        // R10/R1: DMA routing independent of irq, count restart mid-frame
        wr(RA_STATUS, 32'hF);
        wr(RA_IRQSEL, 0);
        wr(RA_EVTSEL, 32'h8);
        p0 = n_pulse;
        vs_pulse();
        lines_irq(6, "R10 irq stays low");
        vs_pulse();
        lines_irq(16, "R1 count restarts at vsync");
        repeat (3) @(negedge clk);
        check("R10 only end-of-frame pulses", n_pulse - p0, 1);
        check("R10 irq low with routing to dma", irq, 0);
        wr(RA_EVTSEL, 0);
        p0 = n_pulse;
        vs_pulse();
        lines_irq(16, "R10 no routing");
        repeat (3) @(negedge clk);
        check("R10 no pulses when unselected", n_pulse - p0, 0);

        check("R10 scoreboard drained", exp_q.size(), 0);
        done = 1;
        summary();
        $finish;
    end

endmodule